// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This block sequences the power modes of a small microcontroller core. It watches the strobe raised when the core executes its SLEEP instruction. On that strobe it moves the chip from active mode into sleep mode, where only the core clock stops, or into subsleep mode, where the main oscillator also stops. With the direct-transition control set, it can instead stay in active mode and only change the clock divider. While in a low-power mode it looks at the interrupt requests, their per-source enables and the core's global interrupt mask, and decides whether to wake. Leaving subsleep first restarts the oscillator and then waits a selectable settling interval before handing control back to the core.

A low level on the external reset pin overrides everything. The oscillator and all clocks come on at once, and internal reset stays asserted until the pin has been high for a fixed settling interval. The core learns through two one-cycle start strobes when to begin interrupt or reset exception handling. The oscillator itself is outside the block and is represented only by its enable output.

Top module: `pwr_mode_seq`

## Requirements
- R1: After the synchronous reset `rst`, `mode_o` reads 0 (active), `div_cur_o` is 0, `osc_en_o`, `cpu_clk_en_o` and `periph_clk_en_o` are 1, and `int_rst_o`, `irq_exc_start_o` and `rst_exc_start_o` are 0.
- R2: A SLEEP strobe sampled in active mode with `standby_sel_i`=0 and no direct transition taken gives `mode_o`=1 (sleep) from the next cycle on. In sleep mode `cpu_clk_en_o`=0 while `osc_en_o` and `periph_clk_en_o` stay 1.
- R3: The same strobe with `standby_sel_i`=1 gives `mode_o`=2 (subsleep), with `osc_en_o`, `cpu_clk_en_o` and `periph_clk_en_o` all 0.
- R4: `div_cur_o` takes the value of `div_sel_i` only on the clock edge where a SLEEP strobe is sampled in active mode, and only the reset pin clears it. At every other time it holds.
- R5: A wake request counts only if `gmask_i`=0 and at least one bit position i has both `irq_req_i[i]` and `irq_en_i[i]` set. Requests that do not count leave the mode unchanged.
- R6: A counted request in sleep mode returns the block to active mode on the next cycle, with `irq_exc_start_o` high for exactly that one cycle.
- R7: A counted request in subsleep gives `mode_o`=3 (waking) with `osc_en_o`=1 on the next cycle. Waking lasts exactly 2^(k+4) cycles, where k is `stab_sel_i` sampled on the request edge; later changes of `stab_sel_i` have no effect. The block then enters active mode with a one-cycle `irq_exc_start_o`.
- R8: A SLEEP strobe with `dt_en_i`=1, `dt_irq_en_i`=1 and `gmask_i`=0 keeps the block in active mode, applies the new divider and pulses `irq_exc_start_o` for one cycle.
- R9: If `dt_en_i`=1 but `dt_irq_en_i`=0 or `gmask_i`=1, the strobe enters sleep or subsleep as chosen by `standby_sel_i`. While `gmask_i`=1, no request takes the block out of that mode.
- R10: `pin_rst_n_i`=0 sampled in any mode gives `mode_o`=4 (reset hold) on the next cycle, with `osc_en_o`, `cpu_clk_en_o`, `periph_clk_en_o` and `int_rst_o` at 1 and `div_cur_o` at 0. This takes priority over a wake request and over a SLEEP strobe in the same cycle.
- R11: Once the pin is high in reset hold, `mode_o`=5 (reset wait) lasts exactly RST_CYC cycles with `int_rst_o`=1. The block then enters active mode with `int_rst_o`=0 and a one-cycle `rst_exc_start_o`. A low pin during reset wait returns the block to reset hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow system clock |
| rst | input | 1 | Synchronous active-high block reset |
| sleep_exec_i | input | 1 | One-cycle strobe when the SLEEP instruction executes |
| standby_sel_i | input | 1 | Low-power target: 0 sleep, 1 subsleep |
| dt_en_i | input | 1 | Request a direct active-to-active transition |
| dt_irq_en_i | input | 1 | Enable of the direct-transition interrupt |
| div_sel_i | input | DIV_W | Pending active-mode clock divider |
| stab_sel_i | input | STS_W | Wake settling select k, 2^(k+4) cycles |
| gmask_i | input | 1 | Core global interrupt mask (1 = masked) |
| irq_req_i | input | NSRC | Interrupt requests |
| irq_en_i | input | NSRC | Per-source interrupt enables |
| pin_rst_n_i | input | 1 | External reset pin, active low |
| mode_o | output | 3 | 0 active, 1 sleep, 2 subsleep, 3 waking, 4 reset hold, 5 reset wait |
| osc_en_o | output | 1 | Main oscillator enable |
| cpu_clk_en_o | output | 1 | Core clock gate enable |
| periph_clk_en_o | output | 1 | Peripheral clock gate enable |
| div_cur_o | output | DIV_W | Divider in force for active mode |
| int_rst_o | output | 1 | Internal reset to core and peripherals |
| irq_exc_start_o | output | 1 | One-cycle start of interrupt exception handling |
| rst_exc_start_o | output | 1 | One-cycle start of reset exception handling |

## Verification
Two pairs of events can land on the same edge: a reset-pin fall together with a counted wake request in subsleep, and a reset-pin fall together with a SLEEP strobe in active mode. The bench drives both inputs at the same falling edge. It expects reset hold and a cleared divider on the next cycle, with no interrupt start and no entry into the waking or sleep modes. A behavioural model predicts every output on every cycle, so a design that lets the wake or the strobe win shows up at once as a mode, divider or strobe mismatch.

// File: rtl/pms_pkg.sv
package pms_pkg;
  typedef enum logic [2:0] {
    PM_ACTIVE   = 3'd0,
    PM_SLEEP    = 3'd1,
    PM_SUBSLEEP = 3'd2,
    PM_WAKING   = 3'd3,
    PM_RST_HOLD = 3'd4,
    PM_RST_WAIT = 3'd5
  } pm_state_t;
endpackage

// File: rtl/pms_wake_qual.sv
module pms_wake_qual #(
  parameter int NSRC = 4
) (
  input  logic            gmask_i,
  input  logic [NSRC-1:0] irq_req_i,
  input  logic [NSRC-1:0] irq_en_i,
  input  logic            dt_en_i,
  input  logic            dt_irq_en_i,
  output logic            wake_o,
  output logic            dt_ok_o
);
  logic [NSRC-1:0] live;

  // per-source qualification, one gate per source
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign live[g] = irq_req_i[g] & irq_en_i[g];
  end

  assign wake_o  = !gmask_i && (|live);
  assign dt_ok_o = dt_en_i && dt_irq_en_i && !gmask_i;
endmodule

// File: rtl/pms_stab_timer.sv
module pms_stab_timer #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  input  logic             run_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (ld_i) begin
      cnt <= ld_val_i;
    end else if (run_i && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero_o = (cnt == '0);

  AST_TMR_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!ld_i && cnt == '0) |=> (cnt == '0)); // R7
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pms_pkg::*;
#(
  parameter int NSRC      = 4,
  parameter int DIV_W     = 3,
  parameter int STS_W     = 3,
  parameter int STAB_BASE = 4,
  parameter int RST_CYC   = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sleep_exec_i,
  input  logic             standby_sel_i,
  input  logic             dt_en_i,
  input  logic             dt_irq_en_i,
  input  logic [DIV_W-1:0] div_sel_i,
  input  logic [STS_W-1:0] stab_sel_i,
  input  logic             gmask_i,
  input  logic [NSRC-1:0]  irq_req_i,
  input  logic [NSRC-1:0]  irq_en_i,
  input  logic             pin_rst_n_i,
  output logic [2:0]       mode_o,
  output logic             osc_en_o,
  output logic             cpu_clk_en_o,
  output logic             periph_clk_en_o,
  output logic [DIV_W-1:0] div_cur_o,
  output logic             int_rst_o,
  output logic             irq_exc_start_o,
  output logic             rst_exc_start_o
);
  localparam int STAB_BITS = STAB_BASE + (1 << STS_W) - 1;
  localparam int RST_BITS  = (RST_CYC > 1) ? $clog2(RST_CYC) : 1;
  localparam int CNT_W     = (STAB_BITS > RST_BITS) ? STAB_BITS : RST_BITS;
  localparam logic [CNT_W-1:0] RST_LOAD = CNT_W'(RST_CYC - 1);

  pm_state_t        st, nxt;
  logic [DIV_W-1:0] div_q, div_n;
  logic             wake, dt_ok, tmr_zero;
  logic             tmr_ld, tmr_run, irq_p, rst_p;
  logic [CNT_W-1:0] tmr_val, stab_load;

  pms_wake_qual #(.NSRC(NSRC)) u_qual (
    .gmask_i     (gmask_i),
    .irq_req_i   (irq_req_i),
    .irq_en_i    (irq_en_i),
    .dt_en_i     (dt_en_i),
    .dt_irq_en_i (dt_irq_en_i),
    .wake_o      (wake),
    .dt_ok_o     (dt_ok)
  );

  pms_stab_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .ld_i     (tmr_ld),
    .ld_val_i (tmr_val),
    .run_i    (tmr_run),
    .zero_o   (tmr_zero)
  );

  // 2^(k+STAB_BASE) cycles, loaded as terminal count minus one
  assign stab_load = (CNT_W'(1) << (32'(stab_sel_i) + STAB_BASE)) - CNT_W'(1);

  always_comb begin
    nxt     = st;
    div_n   = div_q;
    irq_p   = 1'b0;
    rst_p   = 1'b0;
    tmr_ld  = 1'b0;
    tmr_run = 1'b0;
    tmr_val = '0;
    if (!pin_rst_n_i) begin
      nxt   = PM_RST_HOLD;
      div_n = '0;
    end else begin
      unique case (st)
        PM_ACTIVE: if (sleep_exec_i) begin
          div_n = div_sel_i;
          if (dt_ok) irq_p = 1'b1;
          else       nxt   = standby_sel_i ? PM_SUBSLEEP : PM_SLEEP;
        end
        PM_SLEEP: if (wake) begin
          nxt   = PM_ACTIVE;
          irq_p = 1'b1;
        end
        PM_SUBSLEEP: if (wake) begin
          nxt     = PM_WAKING;
          tmr_ld  = 1'b1;
          tmr_val = stab_load;
        end
        PM_WAKING: begin
          tmr_run = 1'b1;
          if (tmr_zero) begin
            nxt   = PM_ACTIVE;
            irq_p = 1'b1;
          end
        end
        PM_RST_HOLD: begin
          nxt     = PM_RST_WAIT;
          tmr_ld  = 1'b1;
          tmr_val = RST_LOAD;
        end
        PM_RST_WAIT: begin
          tmr_run = 1'b1;
          if (tmr_zero) begin
            nxt   = PM_ACTIVE;
            rst_p = 1'b1;
          end
        end
        default: nxt = PM_ACTIVE;
      endcase
    end
  end

  // outputs registered from the next-state decode
  always_ff @(posedge clk) begin
    if (rst) begin
      st              <= PM_ACTIVE;
      div_q           <= '0;
      osc_en_o        <= 1'b1;
      cpu_clk_en_o    <= 1'b1;
      periph_clk_en_o <= 1'b1;
      int_rst_o       <= 1'b0;
      irq_exc_start_o <= 1'b0;
      rst_exc_start_o <= 1'b0;
    end else begin
      st              <= nxt;
      div_q           <= div_n;
      osc_en_o        <= (nxt != PM_SUBSLEEP);
      cpu_clk_en_o    <= (nxt == PM_ACTIVE) || (nxt == PM_RST_HOLD) || (nxt == PM_RST_WAIT);
      periph_clk_en_o <= (nxt != PM_SUBSLEEP) && (nxt != PM_WAKING);
      int_rst_o       <= (nxt == PM_RST_HOLD) || (nxt == PM_RST_WAIT);
      irq_exc_start_o <= irq_p;
      rst_exc_start_o <= rst_p;
    end
  end

  assign mode_o    = st;
  assign div_cur_o = div_q;

  AST_RESET_PRIORITY: assert property (@(posedge clk) disable iff (rst)
    !pin_rst_n_i |=> (mode_o == 3'd4 && int_rst_o && div_cur_o == '0)); // R10
  AST_MASK_HOLDS_SUB: assert property (@(posedge clk) disable iff (rst)
    (st == PM_SUBSLEEP && gmask_i && pin_rst_n_i) |=> (st == PM_SUBSLEEP)); // R9
  AST_DIV_HELD: assert property (@(posedge clk) disable iff (rst)
    (pin_rst_n_i && !(st == PM_ACTIVE && sleep_exec_i)) |=> $stable(div_cur_o)); // R4
  AST_IRQ_LANDS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    irq_exc_start_o |-> (mode_o == 3'd0 && !int_rst_o)); // R6
  AST_RST_START_AFTER_WAIT: assert property (@(posedge clk) disable iff (rst)
    rst_exc_start_o |-> ($past(st) == PM_RST_WAIT)); // R11
  AST_SUB_OSC_OFF: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 3'd2) |-> (!osc_en_o && !cpu_clk_en_o)); // R3
endmodule

// File: tb/sim_pwr_mode_seq.sv
`timescale 1ns/1ps
module sim_pwr_mode_seq;
  localparam int NSRC = 4, DIV_W = 3, STS_W = 3, RST_CYC = 32;

  logic clk = 1'b0, rst = 1'b1;
  logic sleep_exec = 0, standby_sel = 0, dt_en = 0, dt_irq_en = 0, gmask = 0, pin_n = 1;
  logic [DIV_W-1:0] div_sel = '0;
  logic [STS_W-1:0] stab_sel = '0;
  logic [NSRC-1:0]  irq_req = '0, irq_en = '0;
  logic [2:0] mode;
  logic osc_en, cpu_en, per_en, int_rst, irq_st, rst_st;
  logic [DIV_W-1:0] div_cur;

  int checks = 0, errors = 0;
  bit live = 0, done = 0;

  always #4 clk = ~clk;

  pwr_mode_seq #(.NSRC(NSRC), .DIV_W(DIV_W), .STS_W(STS_W), .RST_CYC(RST_CYC)) u0 (
    .clk(clk), .rst(rst), .sleep_exec_i(sleep_exec), .standby_sel_i(standby_sel),
    .dt_en_i(dt_en), .dt_irq_en_i(dt_irq_en), .div_sel_i(div_sel), .stab_sel_i(stab_sel),
    .gmask_i(gmask), .irq_req_i(irq_req), .irq_en_i(irq_en), .pin_rst_n_i(pin_n),
    .mode_o(mode), .osc_en_o(osc_en), .cpu_clk_en_o(cpu_en), .periph_clk_en_o(per_en),
    .div_cur_o(div_cur), .int_rst_o(int_rst), .irq_exc_start_o(irq_st), .rst_exc_start_o(rst_st));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_mode = 0, m_div = 0, m_left = 0;
  bit m_irq = 0, m_rst = 0;
  always @(posedge clk) begin
    bit w;
    w = !gmask && ((irq_req & irq_en) != 0);
    m_irq = 0; m_rst = 0;
    if (rst) begin m_mode = 0; m_div = 0; m_left = 0; end
    else if (!pin_n) begin m_mode = 4; m_div = 0; end
    else if (m_mode == 0) begin
      if (sleep_exec) begin
        m_div = div_sel;
        if (dt_en && dt_irq_en && !gmask) m_irq = 1;
        else m_mode = standby_sel ? 2 : 1;
      end
    end else if (m_mode == 1) begin
      if (w) begin m_mode = 0; m_irq = 1; end
    end else if (m_mode == 2) begin
      if (w) begin m_mode = 3; m_left = 1 << (int'(stab_sel) + 4); end
    end else if (m_mode == 3) begin
      m_left--;
      if (m_left == 0) begin m_mode = 0; m_irq = 1; end
    end else if (m_mode == 4) begin
      m_mode = 5; m_left = RST_CYC;
    end else begin
      m_left--;
      if (m_left == 0) begin m_mode = 0; m_rst = 1; end
    end
    live = 1;
  end

  always @(negedge clk) if (live && !done) begin
    chk("R5 mode", mode, m_mode);
    chk("R4 divider", div_cur, m_div);
    chk("R3 osc_en", osc_en, m_mode != 2);
    chk("R2 cpu_clk", cpu_en, m_mode == 0 || m_mode >= 4);
    chk("R2 periph_clk", per_en, m_mode != 2 && m_mode != 3);
    chk("R11 int_rst", int_rst, m_mode >= 4);
    chk("R6 irq_start", irq_st, m_irq);
    chk("R11 rst_start", rst_st, m_rst);
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sleep_pulse();
    sleep_exec = 1; step(1); sleep_exec = 0;
  endtask

  task automatic count_mode(input int md, output int n);
    n = 0;
    while (mode == md && n < 5000) begin n++; step(1); end
  endtask

  task automatic subsleep_wake(input int k, input string tag);
    int n;
    stab_sel = k[STS_W-1:0]; standby_sel = 1; dt_en = 0;
    sleep_pulse();
    chk({tag, " subsleep entered"}, mode, 2);
    irq_req = 4'b0010; irq_en = 4'b0010;
    step(1);
    chk({tag, " waking osc on"}, osc_en, 1);
    irq_req = '0; stab_sel = ~stab_sel;
    count_mode(3, n);
    chk({tag, " waking length"}, n, 1 << (k + 4));
    chk({tag, " irq start after wake"}, irq_st, 1);
    step(1);
    chk({tag, " irq start one cycle"}, irq_st, 0);
  endtask

  initial begin
    int n;
    step(3); rst = 0; step(1);
    // R1 reset state
    chk("R1 mode", mode, 0); chk("R1 div", div_cur, 0); chk("R1 osc", osc_en, 1);
    chk("R1 cpu", cpu_en, 1); chk("R1 int_rst", int_rst, 0); chk("R1 irq", irq_st, 0);
    // R4 divider ignored without SLEEP
    div_sel = 5; step(3);
    chk("R4 div held", div_cur, 0);
    // R2 sleep entry
    standby_sel = 0; sleep_pulse();
    chk("R2 sleep mode", mode, 1); chk("R2 cpu off", cpu_en, 0); chk("R2 periph on", per_en, 1);
    chk("R4 div applied", div_cur, 5);
    div_sel = 2; step(2);
    chk("R4 div held in sleep", div_cur, 5);
    // R5 unqualified requests
    irq_req = 4'b0010; irq_en = 4'b0001; step(3);
    chk("R5 disabled source", mode, 1);
    irq_en = 4'b0010; gmask = 1; step(3);
    chk("R5 masked", mode, 1);
    // R6 wake from sleep
    gmask = 0; step(1);
    chk("R6 active", mode, 0); chk("R6 irq start", irq_st, 1);
    irq_req = '0; step(1);
    chk("R6 irq pulse width", irq_st, 0);
    // R3 / R7 subsleep wakes
    subsleep_wake(0, "R7 k0");
    subsleep_wake(2, "R7 k2");
    subsleep_wake(7, "R7 k7");
    // R8 direct transition
    dt_en = 1; dt_irq_en = 1; div_sel = 3; standby_sel = 1; sleep_pulse();
    chk("R8 stay active", mode, 0); chk("R8 div", div_cur, 3); chk("R8 irq start", irq_st, 1);
    // R9 fallback, interrupt disabled
    dt_irq_en = 0; standby_sel = 0; sleep_pulse();
    chk("R9 fallback sleep", mode, 1);
    irq_req = 4'b1000; irq_en = 4'b1000; step(1);
    chk("R9 wake back", mode, 0);
    irq_req = '0; step(1);
    // R9 fallback, global mask set: never wakes
    gmask = 1; dt_irq_en = 1; standby_sel = 1; sleep_pulse();
    chk("R9 masked subsleep", mode, 2);
    irq_req = 4'b1111; irq_en = 4'b1111; step(20);
    chk("R9 mask blocks wake", mode, 2);
    // R10 reset pin and wake in the same cycle
    gmask = 0; pin_n = 0; step(1);
    chk("R10 hold", mode, 4); chk("R10 osc", osc_en, 1); chk("R10 cpu", cpu_en, 1);
    chk("R10 div cleared", div_cur, 0); chk("R10 no irq", irq_st, 0);
    irq_req = '0; step(4);
    // R11 reset wait length
    pin_n = 1; step(1);
    chk("R11 wait mode", mode, 5);
    count_mode(5, n);
    chk("R11 wait length", n, RST_CYC);
    chk("R11 rst start", rst_st, 1); chk("R11 int_rst low", int_rst, 0);
    // R11 pin drop during wait
    pin_n = 0; step(1); pin_n = 1; step(10);
    chk("R11 still waiting", mode, 5);
    pin_n = 0; step(1);
    chk("R11 back to hold", mode, 4);
    pin_n = 1; step(1); count_mode(5, n);
    chk("R11 wait restart", n, RST_CYC);
    // R10 reset pin with SLEEP strobe
    dt_en = 0; standby_sel = 0; div_sel = 6;
    sleep_exec = 1; pin_n = 0; step(1); sleep_exec = 0;
    chk("R10 beats sleep", mode, 4); chk("R10 div zero", div_cur, 0);
    pin_n = 1; step(1); count_mode(5, n); step(2);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    done = 1;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule